// File: doc/BRIEF.md
# Programmable Divide-by-N Counter

This block divides an incoming clock, taken from the oscillator being controlled, by a ratio chosen on a 9-bit parallel code. It produces one pulse every N input cycles. That pulse goes to a phase comparator, which sets it against a fixed reference. The code is a binary number. Any code from 2 up to 511 gives a ratio equal to its own value. The two smallest codes are remapped to ratios 2 and 3, so the divider never runs at ratio 0 or 1. An input pin left open on the board must be pulled to logic 0 outside the block, and the block then reads it as 0.

The code is a quasi-static setting, and the counter does not follow it continuously. At each terminal count the counter reloads from the code value present on that edge. A new setting therefore first shows up in the length of the following division period, and the period already running is never cut short or stretched. Two outputs are given. The terminal-count strobe is decoded from the counter state. The divided pulse is a registered, glitch-free copy of the strobe, delayed by one input cycle.

Top module: `progdiv_top`

## Requirements
- R1: The code is read as unsigned binary with code[0] least significant and code[8] most significant; for code values 2 to 511 the period of `tc_strobe` and of `div_out` is exactly that many input clock cycles.
- R2: Code value 0 gives a period of 2 input cycles.
- R3: Code value 1 gives a period of 3 input cycles.
- R4: `tc_strobe` is high for exactly one input cycle per period and never in two consecutive cycles.
- R5: `div_out` is high in exactly the cycle after each cycle in which `tc_strobe` is high, and low in every other cycle.
- R6: The code is sampled only on the clock edge at which `tc_strobe` is high; a code change between terminal counts leaves the period in progress unchanged and sets the length of the next period.
- R7: While `rst` is high at a clock edge, both outputs are low after that edge. After release, `div_out` is first high after the N-th rising edge at which `rst` is low, where N is the ratio of the code present during reset.
- R8: At the largest ratio (code 511) the counter runs without wrapping, and the period is exactly 511 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 9 | Binary divide code, bit 0 least significant |
| div_out | output | 1 | Divided output, one-cycle pulse per period |
| tc_strobe | output | 1 | Terminal-count strobe, one cycle ahead of div_out |

## Verification
A wrong counter value, or a reload that picks the wrong code, changes the distance between pulses. The cycle-level reference model catches this at the first terminal count that lands in the wrong cycle, which is at most one full period (up to 511 cycles) after the fault. A bad remap of the two smallest codes shows up as a 1-cycle or 2-cycle period, or as two strobes in a row, within a few cycles. A reload taken at the wrong moment shows up as a period of the wrong length right after a mid-period code change, so that case is driven on purpose.

// File: rtl/progdiv_pkg.sv
package progdiv_pkg;

    localparam int CODE_W_DEF = 9;

    typedef enum logic [1:0] {
        CLS_FORCE2 = 2'd0,
        CLS_FORCE3 = 2'd1,
        CLS_DIRECT = 2'd2
    } code_class_e;

    function automatic code_class_e classify_code(input logic zero, input logic one);
        if (zero)     return CLS_FORCE2;
        else if (one) return CLS_FORCE3;
        else          return CLS_DIRECT;
    endfunction

endpackage

// File: rtl/progdiv_map.sv
module progdiv_map
    import progdiv_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] reload
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
    localparam logic [CODE_W-1:0] TWO = CODE_W'(2);

    code_class_e cls;

    always_comb begin
        cls = classify_code(code == '0, code == ONE);
        unique case (cls)
            CLS_FORCE2: reload = ONE;
            CLS_FORCE3: reload = TWO;
            default:    reload = code - ONE;
        endcase
    end

    AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (rst) reload != '0); // R2
endmodule

// File: rtl/progdiv_counter.sv
module progdiv_counter #(
    parameter int CODE_W = progdiv_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] reload,
    output logic              tc
);
    localparam logic [CODE_W-1:0] CNT_MAX = {{(CODE_W-1){1'b1}}, 1'b0};

    logic [CODE_W-1:0] cnt;

    assign tc = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || tc) cnt <= reload;
        else           cnt <= cnt - CODE_W'(1);
    end

    AST_RELOAD_AT_TC: assert property (@(posedge clk) disable iff (rst)
        tc |=> cnt == $past(reload)); // R6
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        !tc |=> cnt == CODE_W'($past(cnt) - CODE_W'(1))); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_MAX); // R8
endmodule

// File: rtl/progdiv_pulse.sv
module progdiv_pulse (
    input  logic clk,
    input  logic rst,
    input  logic tc,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= tc;
    end

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tc |=> pulse); // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R5
endmodule

// File: rtl/progdiv_top.sv
module progdiv_top
    import progdiv_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              div_out,
    output logic              tc_strobe
);
    logic [CODE_W-1:0] reload;
    logic              tc;

    progdiv_map #(.CODE_W(CODE_W)) u_map (
        .clk    (clk),
        .rst    (rst),
        .code   (code),
        .reload (reload)
    );

    progdiv_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .tc     (tc)
    );

    progdiv_pulse u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tc    (tc),
        .pulse (div_out)
    );

    assign tc_strobe = tc;

    AST_TC_SPACED: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !div_out); // R7
endmodule

// File: tb/progdiv_top_tb.sv
module progdiv_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] code = 9'd0;
    logic       div_out;
    logic       tc_strobe;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int  ref_phase = 0;
    int  ref_n     = 2;
    bit  ref_out   = 1'b0;
    bit  model_on  = 1'b1;

    always #2.5 clk = ~clk;

    progdiv_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .code      (code),
        .div_out   (div_out),
        .tc_strobe (tc_strobe)
    );

    function automatic int ratio_of(input int c);
        if (c == 0) return 2;
        if (c == 1) return 3;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: phase counts cycles since the start of a period
    always @(posedge clk) begin
        if (rst) begin
            ref_phase = 0;
            ref_n     = ratio_of(int'(code));
            ref_out   = 1'b0;
        end else begin
            ref_out = (ref_phase == ref_n - 1);
            if (ref_out) begin
                ref_phase = 0;
                ref_n     = ratio_of(int'(code));
            end else begin
                ref_phase++;
            end
        end
    end

    // compare on every cycle, away from the active edge (R4, R5, R7)
    always @(negedge clk) begin
        if (model_on && $time > 6) begin
            check(div_out === ref_out, "R5/R7 div_out", int'(div_out), int'(ref_out));
            check(tc_strobe === (!rst && ref_phase == ref_n - 1), "R4 tc_strobe",
                  int'(tc_strobe), int'(!rst && ref_phase == ref_n - 1));
        end
    end

    task automatic wait_pulse();
        @(negedge clk);
        while (!div_out) @(negedge clk);
    endtask

    task automatic measure(input int exp, input string req);
        int k;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_out);
        check(k == exp, req, k, exp);
    endtask

    task automatic run_code(input int c, input string req);
        @(negedge clk);
        code = 9'(c);
        wait_pulse();   // reload with the new code happened at this pulse
        measure(ratio_of(c), req);
        measure(ratio_of(c), req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(div_out == 1'b0 && tc_strobe == 1'b0, "R7 reset state", int'(div_out), 0);

        // R7: first pulse after the N-th edge following release, code 7
        code = 9'd7;
        @(negedge clk);
        rst = 1'b0;
        begin
            int k;
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!div_out && k < 100);
            check(k == 7, "R7 first pulse", k, 7);
        end

        run_code(0,   "R2 code0");
        run_code(1,   "R3 code1");
        run_code(2,   "R1 code2");
        run_code(3,   "R1 code3");
        run_code(255, "R1 code255");
        run_code(9'h0AA, "R1 code170 bit order");
        run_code(256, "R1 code256 msb");
        run_code(511, "R8 code511");

        // R6: mid-period change keeps the running period
        @(negedge clk);
        code = 9'd10;
        wait_pulse();
        measure(10, "R6 settle");
        repeat (2) @(negedge clk);
        code = 9'd4;
        begin
            int k;
            k = 2;
            do begin
                @(negedge clk);
                k++;
            end while (!div_out);
            check(k == 10, "R6 running period", k, 10);
        end
        measure(4, "R6 next period");

        // R7: reset in mid-period clears the outputs
        repeat (2) @(negedge clk);
        rst = 1'b1;
        code = 9'd5;
        repeat (2) @(negedge clk);
        check(div_out == 1'b0 && tc_strobe == 1'b0, "R7 reset again", int'(div_out), 0);
        rst = 1'b0;
        begin
            int k;
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!div_out && k < 100);
            check(k == 5, "R7 first pulse code5", k, 5);
        end

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        model_on = 1'b0;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule